// File: doc/BRIEF.md
# Boundary Scan Pad Register

This block holds the boundary scan cells for a group of general-purpose pads. Each pad owns three cells that observe its input, its output and its output enable. Every cell has a shift stage. The output and enable cells also have a parallel update stage. An external TAP controller supplies decoded strobes for capture, shift and update. An external instruction decoder supplies two flags: one for sampling and preloading, and one for driving the pads from the chain.

While the sample/preload flag is set, the core keeps driving the pads. The chain can capture a snapshot of all pad signals, shift it out on the serial output while new data comes in from the serial input, and latch the new data into the update stages. While the drive flag is set, the update stages drive the pad output and enable, and the chain keeps working as before. A test-logic-reset input gives the pads back to the core at once and leaves the preloaded data where it is.

Top module: `bsr_pad_chain`

## Requirements
- R1: The chain is 3*NUM_PADS bits long. Bit 0 is the bit presented on tdo_o. Pad p occupies bit 3p (input cell), bit 3p+1 (output cell) and bit 3p+2 (enable cell).
- R2: When capture_dr_i is high at a rising tck_i edge and either instruction flag is set, the cells load pad_in_i, pad_out_o and pad_oe_o in parallel.
- R3: When shift_dr_i is high at a rising tck_i edge and either flag is set, the chain moves one bit toward bit 0 and tdi_i enters the top bit. tdo_o shows bit 0 while a flag is set.
- R4: The update stages load the output and enable cells on a falling tck_i edge while update_dr_i is high and either flag is set. Between updates they do not change, including while the chain shifts.
- R5: While extest_i is set and tlr_i is low, pad_out_o[p] and pad_oe_o[p] equal the update stages of bits 3p+1 and 3p+2.
- R6: While extest_i is clear, pad_out_o and pad_oe_o follow core_out_i and core_oe_i. core_in_o always equals pad_in_i.
- R7: While tlr_i is high, the pads follow the core even when extest_i is set. The update stages keep their contents, so the preloaded values return when tlr_i falls.
- R8: When neither flag is set, tdo_o is 0, and the capture, shift and update strobes have no effect on the chain or the update stages.
- R9: rst_ni low clears every shift stage and every update stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| capture_dr_i | input | 1 | Capture-DR strobe |
| shift_dr_i | input | 1 | Shift-DR strobe |
| update_dr_i | input | 1 | Update-DR strobe |
| tlr_i | input | 1 | Test-logic-reset state active |
| sample_i | input | 1 | Sample/preload instruction selected |
| extest_i | input | 1 | Drive-from-chain instruction selected |
| core_out_i | input | NUM_PADS | Core pad output values |
| core_oe_i | input | NUM_PADS | Core pad output enables |
| core_in_o | output | NUM_PADS | Pad input values delivered to the core |
| pad_in_i | input | NUM_PADS | Values received from the pads |
| pad_out_o | output | NUM_PADS | Output values driven to the pads |
| pad_oe_o | output | NUM_PADS | Output enables driven to the pads |

## Verification
The hardest case to reach is showing that the update stages keep their contents. That covers a full shift under the drive instruction, a test-logic-reset while driving, and strobes given with no instruction active. The update stages can only be seen through the pads while extest_i is set and tlr_i is low. So each sequence first preloads a known pattern and then runs the disturbing stimulus. It then switches back to extest_i alone and reads the pads. Chain contents that were ignored while idle are checked by shifting them out afterwards under sample_i.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    CELL_IN  = 2'd0,
    CELL_OUT = 2'd1,
    CELL_OE  = 2'd2
  } cell_kind_e;

  localparam int unsigned CELLS_PER_PAD = 3;

  function automatic int unsigned cell_idx(int unsigned pad, cell_kind_e kind);
    return pad * CELLS_PER_PAD + int'(kind);
  endfunction
endpackage

// File: rtl/bsr_shift_cell.sv
module bsr_shift_cell (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic cap_en_i,
  input  logic shift_en_i,
  input  logic cap_d_i,
  input  logic si_i,
  output logic so_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)         so_o <= 1'b0;
    else if (cap_en_i)   so_o <= cap_d_i;
    else if (shift_en_i) so_o <= si_i;
  end
endmodule

// File: rtl/bsr_upd_reg.sv
module bsr_upd_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             upd_en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // falling edge keeps pad drive steady across the shift phase
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (upd_en_i) q_o <= d_i;
  end
endmodule

// File: rtl/bsr_pad_mux.sv
module bsr_pad_mux #(
  parameter int unsigned NUM_PADS = 4
) (
  input  logic                sel_chain_i,
  input  logic [NUM_PADS-1:0] core_out_i,
  input  logic [NUM_PADS-1:0] core_oe_i,
  input  logic [NUM_PADS-1:0] upd_out_i,
  input  logic [NUM_PADS-1:0] upd_oe_i,
  output logic [NUM_PADS-1:0] pad_out_o,
  output logic [NUM_PADS-1:0] pad_oe_o
);
  assign pad_out_o = sel_chain_i ? upd_out_i : core_out_i;
  assign pad_oe_o  = sel_chain_i ? upd_oe_i  : core_oe_i;
endmodule

// File: rtl/bsr_pad_chain.sv
module bsr_pad_chain #(
  parameter int unsigned NUM_PADS = 4
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                tdi_i,
  output logic                tdo_o,
  input  logic                capture_dr_i,
  input  logic                shift_dr_i,
  input  logic                update_dr_i,
  input  logic                tlr_i,
  input  logic                sample_i,
  input  logic                extest_i,
  input  logic [NUM_PADS-1:0] core_out_i,
  input  logic [NUM_PADS-1:0] core_oe_i,
  output logic [NUM_PADS-1:0] core_in_o,
  input  logic [NUM_PADS-1:0] pad_in_i,
  output logic [NUM_PADS-1:0] pad_out_o,
  output logic [NUM_PADS-1:0] pad_oe_o
);
  import bsr_pkg::*;

  localparam int unsigned CHAIN_LEN = NUM_PADS * CELLS_PER_PAD;

  logic                  active;
  logic                  drive_chain;
  logic [CHAIN_LEN-1:0]  sh_q;
  logic [CHAIN_LEN-1:0]  cap_d;
  logic [2*NUM_PADS-1:0] upd_d;
  logic [2*NUM_PADS-1:0] upd_q;
  logic [NUM_PADS-1:0]   upd_out;
  logic [NUM_PADS-1:0]   upd_oe;

  assign active      = sample_i | extest_i;
  assign drive_chain = extest_i & ~tlr_i;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    assign cap_d[cell_idx(p, CELL_IN)]  = pad_in_i[p];
    assign cap_d[cell_idx(p, CELL_OUT)] = pad_out_o[p];
    assign cap_d[cell_idx(p, CELL_OE)]  = pad_oe_o[p];
    assign upd_d[2*p]   = sh_q[cell_idx(p, CELL_OUT)];
    assign upd_d[2*p+1] = sh_q[cell_idx(p, CELL_OE)];
    assign upd_out[p]   = upd_q[2*p];
    assign upd_oe[p]    = upd_q[2*p+1];
  end

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    logic si;
    if (i == CHAIN_LEN - 1) begin : g_top
      assign si = tdi_i;
    end else begin : g_mid
      assign si = sh_q[i+1];
    end
    bsr_shift_cell i_cell (
      .tck_i      (tck_i),
      .rst_ni     (rst_ni),
      .cap_en_i   (active & capture_dr_i),
      .shift_en_i (active & shift_dr_i),
      .cap_d_i    (cap_d[i]),
      .si_i       (si),
      .so_o       (sh_q[i])
    );
  end

  bsr_upd_reg #(.WIDTH(2*NUM_PADS)) i_upd (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .upd_en_i (active & update_dr_i),
    .d_i      (upd_d),
    .q_o      (upd_q)
  );

  bsr_pad_mux #(.NUM_PADS(NUM_PADS)) i_mux (
    .sel_chain_i (drive_chain),
    .core_out_i  (core_out_i),
    .core_oe_i   (core_oe_i),
    .upd_out_i   (upd_out),
    .upd_oe_i    (upd_oe),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o)
  );

  assign tdo_o     = active & sh_q[0];
  assign core_in_o = pad_in_i;
endmodule

// File: rtl/bsr_pad_chain_chk.sv
module bsr_pad_chain_chk #(
  parameter int unsigned NUM_PADS = 4
) (
  input logic                tck_i,
  input logic                rst_ni,
  input logic                tdo_o,
  input logic                capture_dr_i,
  input logic                update_dr_i,
  input logic                tlr_i,
  input logic                sample_i,
  input logic                extest_i,
  input logic [NUM_PADS-1:0] core_out_i,
  input logic [NUM_PADS-1:0] core_oe_i,
  input logic [NUM_PADS-1:0] pad_in_i,
  input logic [NUM_PADS-1:0] pad_out_o,
  input logic [NUM_PADS-1:0] pad_oe_o
);
  AST_TDO_IDLE_ZERO: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(sample_i || extest_i) |-> !tdo_o); // R8

  AST_CAPTURE_PAD0_IN: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ((sample_i || extest_i) && capture_dr_i) |=>
      (!(sample_i || extest_i) || tdo_o == $past(pad_in_i[0]))); // R2

  AST_UPD_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (extest_i && !tlr_i && $past(extest_i && !tlr_i) && !update_dr_i) |->
      ($stable(pad_out_o) && $stable(pad_oe_o))); // R4

  AST_CORE_OWNS_PADS: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!extest_i || tlr_i) |-> (pad_out_o == core_out_i && pad_oe_o == core_oe_i)); // R6 R7
endmodule

bind bsr_pad_chain bsr_pad_chain_chk #(.NUM_PADS(NUM_PADS)) i_chk (
  .tck_i        (tck_i),
  .rst_ni       (rst_ni),
  .tdo_o        (tdo_o),
  .capture_dr_i (capture_dr_i),
  .update_dr_i  (update_dr_i),
  .tlr_i        (tlr_i),
  .sample_i     (sample_i),
  .extest_i     (extest_i),
  .core_out_i   (core_out_i),
  .core_oe_i    (core_oe_i),
  .pad_in_i     (pad_in_i),
  .pad_out_o    (pad_out_o),
  .pad_oe_o     (pad_oe_o)
);

// File: tb/test_bsr_pad_chain.sv
`timescale 1ns/1ps
module test_bsr_pad_chain;
  localparam int N = 4;
  localparam int L = 3 * N;

  logic tck = 1'b0;
  logic rst_ni = 1'b0;
  logic tdi = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0;
  logic tlr = 1'b0, sample = 1'b0, extest = 1'b0;
  logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic tdo;
  logic [N-1:0] core_in, pad_out, pad_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  bsr_pad_chain #(.NUM_PADS(N)) i_bsr_pad_chain (
    .tck_i(tck), .rst_ni(rst_ni), .tdi_i(tdi), .tdo_o(tdo),
    .capture_dr_i(capture), .shift_dr_i(shift), .update_dr_i(update),
    .tlr_i(tlr), .sample_i(sample), .extest_i(extest),
    .core_out_i(core_out), .core_oe_i(core_oe), .core_in_o(core_in),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic tick();
    @(posedge tck);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] pack(logic [N-1:0] i_v, logic [N-1:0] o_v, logic [N-1:0] e_v);
    logic [L-1:0] v;
    for (int p = 0; p < N; p++) begin
      v[3*p] = i_v[p]; v[3*p+1] = o_v[p]; v[3*p+2] = e_v[p];
    end
    return v;
  endfunction

  function automatic logic [N-1:0] outs(logic [L-1:0] v);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = v[3*p+1];
    return r;
  endfunction

  function automatic logic [N-1:0] oes(logic [L-1:0] v);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = v[3*p+2];
    return r;
  endfunction

  task automatic do_capture();
    capture = 1'b1; tick(); capture = 1'b0;
  endtask

  task automatic do_update();
    update = 1'b1; tick(); update = 1'b0;
  endtask

  task automatic do_shift(input logic [L-1:0] din, output logic [L-1:0] dout);
    shift = 1'b1;
    for (int i = 0; i < L; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      tick();
    end
    shift = 1'b0;
    tdi = 1'b0;
  endtask

  logic [L-1:0] pat_a = 12'hA5C;
  logic [L-1:0] pat_b = 12'h3B6;
  logic [L-1:0] pat_c = 12'h6E1;

  task automatic t_reset();
    logic [L-1:0] d;
    sample = 1'b1; core_out = 4'h9; core_oe = 4'h3; tick();
    chk("R9 tdo after reset", tdo, 0);
    chk("R6 pads follow core", {pad_out, pad_oe}, {4'h9, 4'h3});
    do_shift('0, d);
    chk("R9 chain cleared", d, 0);
    sample = 1'b0; extest = 1'b1; tick();
    chk("R9 update stages cleared", {pad_out, pad_oe}, 0);
    extest = 1'b0; tick();
  endtask

  task automatic t_sample_capture();
    logic [L-1:0] d;
    sample = 1'b1; pad_in = 4'b1010; core_out = 4'b0110; core_oe = 4'b1100; tick();
    chk("R6 core_in passthrough", core_in, 4'b1010);
    do_capture();
    chk("R2 tdo shows pad0 input", tdo, 0);
    do_shift(pat_a, d);
    chk("R1 R2 R3 captured order", d, pack(4'b1010, 4'b0110, 4'b1100));
    pad_in = 4'b0101; core_out = 4'b1001; core_oe = 4'b0011;
    do_capture();
    chk("R2 tdo second capture", tdo, 1);
    do_shift(pat_a, d);
    chk("R1 R2 second pattern", d, pack(4'b0101, 4'b1001, 4'b0011));
    chk("R6 sample leaves pads on core", {pad_out, pad_oe}, {4'b1001, 4'b0011});
    do_update();
    chk("R6 pads on core after preload", {pad_out, pad_oe}, {4'b1001, 4'b0011});
    sample = 1'b0; extest = 1'b1; tick();
    chk("R4 R5 preloaded A on pads", {pad_out, pad_oe}, {outs(pat_a), oes(pat_a)});
  endtask

  task automatic t_extest();
    logic [L-1:0] d;
    core_out = 4'hF; core_oe = 4'hF; pad_in = 4'b0110;
    do_shift(pat_b, d);
    chk("R3 full shift returns preloaded A", d, pat_a);
    chk("R4 pads hold A through shift", {pad_out, pad_oe}, {outs(pat_a), oes(pat_a)});
    do_update();
    chk("R4 R5 pads now B", {pad_out, pad_oe}, {outs(pat_b), oes(pat_b)});
    do_capture();
    do_shift(pat_c, d);
    chk("R2 extest capture sees driven pads", d, pack(4'b0110, outs(pat_b), oes(pat_b)));
  endtask

  task automatic t_tlr();
    tlr = 1'b1; core_out = 4'h5; core_oe = 4'hA; tick();
    chk("R7 tlr gives pads to core", {pad_out, pad_oe}, {4'h5, 4'hA});
    tlr = 1'b0; tick();
    chk("R7 update stages retained", {pad_out, pad_oe}, {outs(pat_b), oes(pat_b)});
  endtask

  task automatic t_idle();
    logic [L-1:0] d;
    extest = 1'b0; tick();
    chk("R8 tdo zero idle", tdo, 0);
    pad_in = 4'hF; core_out = 4'h0; core_oe = 4'h0;
    do_capture();
    do_shift('1, d);
    chk("R8 tdo zero during idle shift", d, 0);
    do_update();
    extest = 1'b1; tick();
    chk("R8 update ignored idle", {pad_out, pad_oe}, {outs(pat_b), oes(pat_b)});
    extest = 1'b0; sample = 1'b1; tick();
    do_shift('0, d);
    chk("R8 chain unchanged idle", d, pat_c);
    sample = 1'b0; tick();
  endtask

  task automatic t_reset_mid();
    #1 rst_ni = 1'b0; #1;
    extest = 1'b1; #1;
    chk("R9 reset clears update stages", {pad_out, pad_oe}, 0);
    extest = 1'b0; tick();
    rst_ni = 1'b1; tick();
    sample = 1'b1; #1;
    chk("R9 reset clears chain bit0", tdo, 0);
    sample = 1'b0; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_sample_capture();
    t_extest();
    t_tlr();
    t_idle();
    t_reset_mid();
    finish_run();
  end
endmodule